// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block splits a loop with a run-time trip count into pieces that a vector unit can take in one pass. No piece is longer than a compile-time maximum vector length. A single start pulse supplies the trip count and a base element index. The sequencer then hands out one descriptor per piece over a valid/ready handshake. Each descriptor carries the index of the piece's first element and the number of elements in the piece.

The short, odd-sized piece (trip count modulo the maximum length) goes out first. Every piece after it is exactly the maximum length. When the trip count is an exact multiple, the empty leading piece is skipped. After the last piece has been accepted, the sequencer pulses done for one cycle and returns to idle. A trip count of zero produces only the done pulse. The block computes indices and lengths only; it never sees the data.

Top module: `stripSequencer`

## Requirements
- R1: After reset, chunkValid, seqDone and busy are all low.
- R2: A start with tripCount not a multiple of MVL yields a first descriptor with chunkLow = baseIdx and chunkLen = tripCount mod MVL.
- R3: Every descriptor after the first has chunkLen = MVL.
- R4: Each descriptor's chunkLow equals the previous descriptor's chunkLow plus the previous chunkLen, modulo 2^IDX_W.
- R5: A start with tripCount = n produces exactly floor(n/MVL) + (n mod MVL != 0) descriptors, and their lengths sum to n.
- R6: A descriptor with chunkLen = 0 is never presented. When tripCount is a nonzero multiple of MVL, the first descriptor has chunkLow = baseIdx and chunkLen = MVL.
- R7: A start with tripCount = 0 raises seqDone in the cycle after the start edge, and no descriptor is presented.
- R8: While chunkValid is high and chunkReady is low, chunkValid, chunkLow and chunkLen hold their values into the next cycle.
- R9: busy is high from the cycle after an accepted start through the seqDone cycle. seqDone is high for exactly one cycle, the cycle after the final handshake. busy is low the cycle after seqDone.
- R10: A startPulse while busy is high is ignored, including in the seqDone cycle and in the cycle of the final handshake. It changes neither the descriptor sequence nor the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a sequence; sampled only when idle |
| tripCount | input | CNT_W | Total element count n |
| baseIdx | input | IDX_W | Index of the first element |
| chunkValid | output | 1 | A descriptor is presented |
| chunkReady | input | 1 | Consumer accepts the descriptor |
| chunkLow | output | IDX_W | First element index of the piece |
| chunkLen | output | LEN_W | Element count of the piece |
| seqDone | output | 1 | One-cycle pulse after the final piece |
| busy | output | 1 | A sequence is in progress |

## Verification
The collision that matters is a new startPulse landing in the same cycle as a handshake. This includes the handshake that retires the final piece, and the seqDone cycle itself. In those cycles the sequencer must both advance or finish and discard the start. The bench sweeps every trip count the small configuration allows, under four ready patterns. On selected runs it drives a foreign start with a different count and base, in a middle cycle, on the final handshake and during seqDone. It then judges the descriptors, the done timing and the later idle state against counts computed arithmetically from n, the base and MVL.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;     // capture trip count and base
    logic advance;  // current piece accepted
  } seqCtl_t;
endpackage

// File: rtl/strip_seq_ctrl.sv
module strip_seq_ctrl
  import strip_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    chunkReady,
  input  logic    isEmpty,
  input  logic    lastChunk,
  output seqCtl_t ctl,
  output logic    chunkValid,
  output logic    seqDone,
  output logic    busy
);
  seqState_t stateQ, stateD;
  logic fire;

  assign chunkValid = (stateQ == ST_RUN);
  assign seqDone    = (stateQ == ST_FIN);
  assign busy       = (stateQ != ST_IDLE);
  assign fire       = chunkValid && chunkReady;

  always_comb begin
    stateD      = stateQ;
    ctl.load    = 1'b0;
    ctl.advance = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (startPulse) begin
        ctl.load = 1'b1;
        stateD   = isEmpty ? ST_FIN : ST_RUN;
      end
      ST_RUN: if (fire) begin
        ctl.advance = 1'b1;
        if (lastChunk) stateD = ST_FIN;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R7
  empty_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse && isEmpty) |=> (seqDone && !chunkValid));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> (!seqDone && !busy && !chunkValid));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && !chunkReady && startPulse) |=> chunkValid);
endmodule

// File: rtl/strip_seq_dpath.sv
module strip_seq_dpath
  import strip_seq_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int CNT_W = 16,
  parameter int IDX_W = 16,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [CNT_W-1:0] tripCount,
  input  logic [IDX_W-1:0] baseIdx,
  output logic             isEmpty,
  output logic             lastChunk,
  output logic [IDX_W-1:0] chunkLow,
  output logic [LEN_W-1:0] chunkLen
);
  localparam logic [CNT_W-1:0] MVL_C = CNT_W'(MVL);
  localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

  logic [CNT_W-1:0] fullPart, remPart, fullLeftQ;
  logic [IDX_W-1:0] lowQ;
  logic [LEN_W-1:0] lenQ;

  assign fullPart  = tripCount / MVL_C;
  assign remPart   = tripCount % MVL_C;
  assign isEmpty   = (tripCount == '0);
  assign lastChunk = (fullLeftQ == '0);
  assign chunkLow  = lowQ;
  assign chunkLen  = lenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ      <= '0;
      lenQ      <= '0;
      fullLeftQ <= '0;
    end else if (ctl.load) begin
      lowQ <= baseIdx;
      if (remPart == '0) begin
        lenQ      <= MVL_L;
        fullLeftQ <= (fullPart == '0) ? '0 : fullPart - 1'b1;
      end else begin
        lenQ      <= LEN_W'(remPart);
        fullLeftQ <= fullPart;
      end
    end else if (ctl.advance) begin
      lowQ <= lowQ + IDX_W'(lenQ);
      lenQ <= MVL_L;
      if (!lastChunk) fullLeftQ <= fullLeftQ - 1'b1;
    end
  end

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !lastChunk) |=> (fullLeftQ == $past(fullLeftQ) - 1'b1));
endmodule

// File: rtl/stripSequencer.sv
module stripSequencer
  import strip_seq_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int CNT_W = 16,
  parameter int IDX_W = 16,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] tripCount,
  input  logic [IDX_W-1:0] baseIdx,
  output logic             chunkValid,
  input  logic             chunkReady,
  output logic [IDX_W-1:0] chunkLow,
  output logic [LEN_W-1:0] chunkLen,
  output logic             seqDone,
  output logic             busy
);
  seqCtl_t ctl;
  logic    isEmpty, lastChunk;

  strip_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .chunkReady(chunkReady),
    .isEmpty   (isEmpty),
    .lastChunk (lastChunk),
    .ctl       (ctl),
    .chunkValid(chunkValid),
    .seqDone   (seqDone),
    .busy      (busy)
  );

  strip_seq_dpath #(
    .MVL  (MVL),
    .CNT_W(CNT_W),
    .IDX_W(IDX_W),
    .LEN_W(LEN_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .tripCount(tripCount),
    .baseIdx  (baseIdx),
    .isEmpty  (isEmpty),
    .lastChunk(lastChunk),
    .chunkLow (chunkLow),
    .chunkLen (chunkLen)
  );

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && !chunkReady) |=> (chunkValid && $stable(chunkLow) && $stable(chunkLen)));

  // R4
  low_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkReady) |=>
      (!chunkValid || chunkLow == $past(chunkLow) + IDX_W'($past(chunkLen))));

  // R3
  full_after_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkReady) |=> (!chunkValid || chunkLen == LEN_W'(MVL)));

  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid |-> (chunkLen != '0 && chunkLen <= LEN_W'(MVL)));
endmodule

// File: tb/tb_stripSequencer.sv
module tb_stripSequencer;
  localparam int MVL   = 4;
  localparam int CNT_W = 6;
  localparam int IDX_W = 8;
  localparam int LEN_W = $clog2(MVL + 1);

  logic             clk = 1'b0;
  logic             rstN;
  logic             startPulse;
  logic [CNT_W-1:0] tripCount;
  logic [IDX_W-1:0] baseIdx;
  logic             chunkValid, chunkReady, seqDone, busy;
  logic [IDX_W-1:0] chunkLow;
  logic [LEN_W-1:0] chunkLen;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  stripSequencer #(.MVL(MVL), .CNT_W(CNT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .tripCount(tripCount),
    .baseIdx(baseIdx), .chunkValid(chunkValid), .chunkReady(chunkReady),
    .chunkLow(chunkLow), .chunkLen(chunkLen), .seqDone(seqDone), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit readyOf(int pat, int cyc);
    case (pat)
      0:       return 1'b1;
      1:       return (cyc % 2) == 1;
      2:       return (cyc % 3) != 0;
      default: return ((cyc * 7 + 3) % 5) < 2;
    endcase
  endfunction

  task automatic runOne(input int n, input int base, input int pat, input bit spur);
    int  expChunks = n / MVL + (((n % MVL) != 0) ? 1 : 0);
    int  rem       = n % MVL;
    int  got       = 0;
    int  sumLen    = 0;
    int  nextLow   = base;
    int  cyc       = 0;
    bit  holding   = 1'b0;
    bit  firedLast = 1'b0;
    bit  doneSeen  = 1'b0;
    int  holdLow   = 0;
    int  holdLen   = 0;
    @(negedge clk);
    startPulse = 1'b1;
    tripCount  = CNT_W'(n);
    baseIdx    = IDX_W'(base);
    @(negedge clk);
    startPulse = 1'b0;
    tripCount  = CNT_W'(n + 5);
    baseIdx    = IDX_W'(base + 40);
    check(busy === 1'b1, "R9 busy after start", busy, 1);
    while (!doneSeen && cyc < 4000) begin
      if (seqDone === 1'b1) begin
        doneSeen = 1'b1;
        check(got == expChunks, "R5 chunk count", got, expChunks);
        check(sumLen == n, "R5 length sum", sumLen, n);
        if (n == 0) check(cyc == 0, "R7 empty done timing", cyc, 0);
        else        check(firedLast, "R9 done after last handshake", firedLast, 1);
        check(chunkValid === 1'b0, "R9 no valid with done", chunkValid, 0);
        if (spur) begin
          startPulse = 1'b1;
          tripCount  = CNT_W'(9);
          baseIdx    = IDX_W'(3);
        end
        @(negedge clk);
        startPulse = 1'b0;
        check(seqDone === 1'b0, "R9 done single cycle", seqDone, 0);
        check(busy === 1'b0, "R10 idle after done", busy, 0);
        check(chunkValid === 1'b0, "R10 no restart", chunkValid, 0);
      end else begin
        if (holding) begin
          check(chunkValid === 1'b1 && chunkLow == IDX_W'(holdLow) && int'(chunkLen) == holdLen,
                "R8 held descriptor", int'(chunkLow), holdLow);
        end
        if (n == 0) check(chunkValid === 1'b0, "R7 no descriptor", chunkValid, 0);
        chunkReady = readyOf(pat, cyc);
        startPulse = spur && (cyc == 2);
        tripCount  = CNT_W'(7);
        baseIdx    = IDX_W'(99);
        firedLast  = 1'b0;
        if (chunkValid && chunkReady) begin
          int expLen = (got == 0 && rem != 0) ? rem : MVL;
          check(chunkLow == IDX_W'(nextLow), "R4 chunk low", int'(chunkLow), nextLow % 256);
          if (got == 0 && rem != 0) check(int'(chunkLen) == expLen, "R2 first len", int'(chunkLen), expLen);
          else if (got == 0)        check(int'(chunkLen) == expLen, "R6 first full len", int'(chunkLen), expLen);
          else                      check(int'(chunkLen) == expLen, "R3 full len", int'(chunkLen), expLen);
          if (got == 0) check(chunkLow == IDX_W'(base), "R2 first low", int'(chunkLow), base % 256);
          nextLow  = nextLow + int'(chunkLen);
          sumLen   = sumLen + int'(chunkLen);
          got++;
          firedLast = 1'b1;
          if (spur && got == expChunks) startPulse = 1'b1;
        end
        holding = chunkValid && !chunkReady;
        holdLow = int'(chunkLow);
        holdLen = int'(chunkLen);
        @(negedge clk);
        startPulse = 1'b0;
        cyc++;
      end
    end
    if (!doneSeen) check(1'b0, "R9 sequence never finished", cyc, expChunks);
  endtask

  initial begin
    rstN       = 1'b0;
    startPulse = 1'b0;
    tripCount  = '0;
    baseIdx    = '0;
    chunkReady = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(chunkValid === 1'b0, "R1 reset valid", chunkValid, 0);
    check(seqDone === 1'b0, "R1 reset done", seqDone, 0);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    rstN = 1'b1;
    for (int n = 0; n < (1 << CNT_W); n++) begin
      for (int pat = 0; pat < 4; pat++) begin
        int base = ((n * 37 + pat * 11) % 256);
        if (pat == 3) base = 250;  // index wrap
        runOne(n, base, pat, (n % 2) == 1 || pat == 2);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule